// File: doc/BRIEF.md
# Self-Programming Flash Command Controller

This block is the control and status register that lets the CPU reprogram its own program memory. Software writes one of five exact command codes into the register. The code arms the block for a few clock cycles. A store strobe arriving inside that window becomes one of four actions: a page-buffer word fill, a page-buffer clear, a page erase or a page program. A load strobe becomes a fuse or lock-bit read. Codes that do not match exactly are dropped, and an armed command that sees no strobe expires by itself.

Page erase and page program are long operations. When one starts, the block issues a start pulse to the flash array model, halts the CPU and measures the operation time by counting oscillator ticks. It finishes only when the tick count has reached `OP_TICKS` and the array has acknowledged. A reset that arrives during such an operation does not cut it short.

The sequencer has three states: `ST_IDLE`, `ST_ARMED` and `ST_BUSY`. It makes these transitions:
- arm: `ST_IDLE` to `ST_ARMED`, on an accepted write.
- rearm: `ST_ARMED` to `ST_ARMED`, on an accepted write with no strobe in the same cycle.
- fire-short: `ST_ARMED` to `ST_IDLE`, for a fill, clear or fuse/lock read.
- fire-long: `ST_ARMED` to `ST_BUSY`, for an erase or program.
- expire: `ST_ARMED` to `ST_IDLE`, when the window runs out.
- complete: `ST_BUSY` to `ST_IDLE`.

Top module: `selfprog_ctrl`

## Requirements
- R1: The register reads as `{3'b000, clr_buf, rd_fuse, pg_prog, pg_erase, st_en}`, with bits 4 down to 0 in that order. Bits 7..5 always read zero, and after reset the register reads 8'h00.
- R2: A write is accepted only if its low five bits are 5'b10001 (clear), 5'b01001 (fuse/lock read), 5'b00101 (program), 5'b00011 (erase) or 5'b00001 (fill). Any other write leaves the readback unchanged. The upper three written bits are ignored.
- R3: An accepted fill, clear, erase or program code arms the store strobe for the next `ARM_CYCLES` (4) rising edges. If no store strobe is sampled at any of these edges, the register returns to 8'h00.
- R4: A fill followed by an in-window store strobe gives a one-cycle `buf_we` pulse in the next cycle. The pulse carries `buf_wdata` = R1:R0 and `buf_addr` = `zptr[5:1]`, so Z bit 0 is ignored.
- R5: An erase or program followed by an in-window store strobe gives a one-cycle `flash_start` pulse. The pulse carries `flash_page` = `zptr[15:6]` and `flash_prog` (1 = program, 0 = erase).
- R6: While an erase or program runs, `halt` and `busy` are high, and the register reads 8'h03 (erase) or 8'h05 (program).
- R7: With a tick on every cycle, `halt` stays high for `OP_TICKS`+1 cycles after the strobe edge. If `flash_ack` arrives later, the operation ends at the edge that samples the acknowledge. The register then reads 8'h00.
- R8: A clear followed by an in-window store strobe gives a one-cycle `buf_clr` pulse, and no `buf_we` pulse.
- R9: A fuse/lock read arms the load strobe for `LOAD_CYCLES` (3) edges. A load strobe in that window gives a one-cycle `ld_valid` pulse in the next cycle. `ld_data` is `fuse_bits` when `zptr[0]`=1 and `lock_bits` when `zptr[0]`=0.
- R10: Reset asserted during an erase or program does not end it. `halt` stays high until normal completion.
- R11: Register writes during an erase or program are ignored.
- R12: If a register write and the matching strobe fall in the same armed cycle, the strobe executes the old command and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, ignored while busy |
| osc_tick | input | 1 | One pulse per oscillator period for the operation timer |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback |
| store_strobe | input | 1 | Store-to-program-memory strobe |
| load_strobe | input | 1 | Load-from-program-memory strobe |
| zptr | input | 16 | Z pointer |
| r_data | input | 16 | R1:R0 data word |
| fuse_bits | input | 8 | Fuse bit values |
| lock_bits | input | 8 | Lock bit values |
| buf_we | output | 1 | Page buffer word write pulse |
| buf_addr | output | 5 | Page buffer word index |
| buf_wdata | output | 16 | Page buffer write data |
| buf_clr | output | 1 | Page buffer clear pulse |
| flash_start | output | 1 | Erase/program start pulse |
| flash_prog | output | 1 | 1 = program, 0 = erase |
| flash_page | output | 10 | Page address |
| flash_ack | input | 1 | Array acknowledge of the started operation |
| ld_valid | output | 1 | Fuse/lock read result valid pulse |
| ld_data | output | 8 | Fuse/lock read result |
| halt | output | 1 | CPU halt during erase/program |
| busy | output | 1 | Busy status, mirrors halt |

## Verification
Two events can meet in one armed cycle: a register write, which would rearm the block, and the strobe that consumes the armed command. A reset or write can also land inside a running erase. The bench arms a fill and, in the cycle that carries the store strobe, writes an erase code. The expected result is a buffer write pulse, no flash start, and a register that reads zero afterwards. In the same way, the bench drives a write and a reset pulse into the busy loop of an erase. Readback must stay at the erase image, and the halt length must match the undisturbed value.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_FILL,
        CMD_CLEAR,
        CMD_ERASE,
        CMD_PROG,
        CMD_FUSE
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BUSY
    } state_e;

    // register image {clr_buf, rd_fuse, pg_prog, pg_erase, st_en}
    function automatic logic [4:0] cmd_image(cmd_e c);
        logic [4:0] v;
        unique case (c)
            CMD_FILL:  v = 5'b00001;
            CMD_CLEAR: v = 5'b10001;
            CMD_ERASE: v = 5'b00011;
            CMD_PROG:  v = 5'b00101;
            CMD_FUSE:  v = 5'b01001;
            default:   v = 5'b00000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/selfprog_cmd_decode.sv
module selfprog_cmd_decode
    import selfprog_pkg::*;
(
    input  logic [4:0] pattern,
    output cmd_e       cmd,
    output logic       valid
);
    always_comb begin
        valid = 1'b1;
        unique case (pattern)
            5'b00001: cmd = CMD_FILL;
            5'b10001: cmd = CMD_CLEAR;
            5'b00011: cmd = CMD_ERASE;
            5'b00101: cmd = CMD_PROG;
            5'b01001: cmd = CMD_FUSE;
            default: begin
                cmd   = CMD_NONE;
                valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/selfprog_arm_window.sv
module selfprog_arm_window #(
    parameter int MAX_CYCLES = 4,
    localparam int CW = $clog2(MAX_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = run && (cnt_q == CW'(1));
endmodule

// File: rtl/selfprog_op_timer.sv
module selfprog_op_timer #(
    parameter int TICKS = 4000,
    localparam int TW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (en && tick && cnt_q != TW'(TICKS)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == TW'(TICKS));
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int ZW          = 16,
    parameter int PAGE_WORDS  = 32,
    parameter int ARM_CYCLES  = 4,
    parameter int LOAD_CYCLES = 3,
    parameter int OP_TICKS    = 4000,
    localparam int WA  = $clog2(PAGE_WORDS),
    localparam int PGW = ZW - WA - 1,
    localparam int WMX = (ARM_CYCLES > LOAD_CYCLES) ? ARM_CYCLES : LOAD_CYCLES,
    localparam int CW  = $clog2(WMX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           osc_tick,
    input  logic           reg_we,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic           store_strobe,
    input  logic           load_strobe,
    input  logic [ZW-1:0]  zptr,
    input  logic [15:0]    r_data,
    input  logic [7:0]     fuse_bits,
    input  logic [7:0]     lock_bits,
    output logic           buf_we,
    output logic [WA-1:0]  buf_addr,
    output logic [15:0]    buf_wdata,
    output logic           buf_clr,
    output logic           flash_start,
    output logic           flash_prog,
    output logic [PGW-1:0] flash_page,
    input  logic           flash_ack,
    output logic           ld_valid,
    output logic [7:0]     ld_data,
    output logic           halt,
    output logic           busy
);
    state_e state_q, state_d;
    cmd_e   cmd_q, cmd_d;
    cmd_e   dec_cmd;
    logic   dec_valid;
    logic   ack_seen_q;
    logic   rst_apply;
    logic   wr_ok, hit, fire, start_op;
    logic   win_load, win_last;
    logic [CW-1:0] win_val;
    logic   tmr_expired;

    // reset is held off while a long operation runs
    assign rst_apply = !rst_n && (state_q != ST_BUSY);

    selfprog_cmd_decode u_dec (
        .pattern (reg_wdata[4:0]),
        .cmd     (dec_cmd),
        .valid   (dec_valid)
    );

    assign wr_ok   = reg_we && dec_valid;
    assign hit     = (cmd_q == CMD_FUSE) ? load_strobe : store_strobe;
    assign win_val = (dec_cmd == CMD_FUSE) ? CW'(LOAD_CYCLES) : CW'(ARM_CYCLES);

    selfprog_arm_window #(.MAX_CYCLES(WMX)) u_win (
        .clk      (clk),
        .clr      (rst_apply),
        .load     (win_load),
        .load_val (win_val),
        .run      (state_q == ST_ARMED),
        .last     (win_last)
    );

    selfprog_op_timer #(.TICKS(OP_TICKS)) u_tmr (
        .clk     (clk),
        .clr     (start_op || rst_apply),
        .en      (state_q == ST_BUSY),
        .tick    (osc_tick),
        .expired (tmr_expired)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cmd_d    = cmd_q;
        win_load = 1'b0;
        fire     = 1'b0;
        start_op = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ok) begin
                    state_d  = ST_ARMED;
                    cmd_d    = dec_cmd;
                    win_load = 1'b1;
                end
            end
            ST_ARMED: begin
                if (hit) begin
                    fire = 1'b1;
                    if (cmd_q == CMD_ERASE || cmd_q == CMD_PROG) begin
                        state_d  = ST_BUSY;
                        start_op = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        cmd_d   = CMD_NONE;
                    end
                end else if (wr_ok) begin
                    cmd_d    = dec_cmd;
                    win_load = 1'b1;
                end else if (win_last) begin
                    state_d = ST_IDLE;
                    cmd_d   = CMD_NONE;
                end
            end
            ST_BUSY: begin
                if (tmr_expired && (ack_seen_q || flash_ack)) begin
                    state_d = ST_IDLE;
                    cmd_d   = CMD_NONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cmd_d   = CMD_NONE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst_apply) begin
            state_q    <= ST_IDLE;
            cmd_q      <= CMD_NONE;
            ack_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            if (start_op) begin
                ack_seen_q <= 1'b0;
            end else if (state_q == ST_BUSY && flash_ack) begin
                ack_seen_q <= 1'b1;
            end
        end
    end

    // registered action outputs
    always_ff @(posedge clk) begin
        if (rst_apply) begin
            buf_we      <= 1'b0;
            buf_addr    <= '0;
            buf_wdata   <= '0;
            buf_clr     <= 1'b0;
            flash_start <= 1'b0;
            flash_prog  <= 1'b0;
            flash_page  <= '0;
            ld_valid    <= 1'b0;
            ld_data     <= '0;
        end else begin
            buf_we      <= fire && (cmd_q == CMD_FILL);
            buf_clr     <= fire && (cmd_q == CMD_CLEAR);
            flash_start <= start_op;
            ld_valid    <= fire && (cmd_q == CMD_FUSE);
            if (fire && cmd_q == CMD_FILL) begin
                buf_addr  <= zptr[WA:1];
                buf_wdata <= r_data;
            end
            if (start_op) begin
                flash_prog <= (cmd_q == CMD_PROG);
                flash_page <= zptr[ZW-1:WA+1];
            end
            if (fire && cmd_q == CMD_FUSE) begin
                ld_data <= zptr[0] ? fuse_bits : lock_bits;
            end
        end
    end

    assign reg_rdata = {3'b000, cmd_image(cmd_q)};
    assign halt      = (state_q == ST_BUSY);
    assign busy      = halt;
endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
    parameter int ARM_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       buf_we,
    input logic       buf_clr,
    input logic       flash_start,
    input logic       ld_valid,
    input logic       halt,
    input logic       busy
);
    localparam int AW = $clog2(ARM_CYCLES + 2);
    logic [AW-1:0] armed_cnt;
    logic          armed;

    assign armed = reg_rdata[0] && !halt;

    always_ff @(posedge clk) begin
        if (!rst_n || !armed || reg_we) begin
            armed_cnt <= '0;
        end else if (armed_cnt != {AW{1'b1}}) begin
            armed_cnt <= armed_cnt + 1'b1;
        end
    end

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:5] == 3'b000);

    a_r2_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && reg_rdata == 8'h00 && reg_we && reg_wdata[4:0] == 5'b00111)
        |=> reg_rdata == 8'h00);

    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        armed_cnt <= AW'(ARM_CYCLES));

    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        flash_start |=> !flash_start);

    a_r5_start_halts: assert property (@(posedge clk) disable iff (!rst_n)
        flash_start |-> halt);

    a_r6_halt_image: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (reg_rdata[0] && (reg_rdata[1] ^ reg_rdata[2]) && busy));

    a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_we, buf_clr, flash_start, ld_valid}));

    a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && reg_we) |=> (!halt || $stable(reg_rdata)));
endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(.ARM_CYCLES(ARM_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .buf_we      (buf_we),
    .buf_clr     (buf_clr),
    .flash_start (flash_start),
    .ld_valid    (ld_valid),
    .halt        (halt),
    .busy        (busy)
);

// File: tb/selfprog_ctrl_tb.sv
`timescale 1ns/1ps
module selfprog_ctrl_tb;
    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        store_strobe = 1'b0;
    logic        load_strobe = 1'b0;
    logic [15:0] zptr = '0;
    logic [15:0] r_data = '0;
    logic [7:0]  fuse_bits = 8'hA5;
    logic [7:0]  lock_bits = 8'h3C;
    logic        buf_we, buf_clr, flash_start, flash_prog, ld_valid, halt, busy;
    logic [4:0]  buf_addr;
    logic [15:0] buf_wdata;
    logic [9:0]  flash_page;
    logic        flash_ack = 1'b0;
    logic [7:0]  ld_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    selfprog_ctrl #(.OP_TICKS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .store_strobe(store_strobe), .load_strobe(load_strobe),
        .zptr(zptr), .r_data(r_data), .fuse_bits(fuse_bits), .lock_bits(lock_bits),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_clr(buf_clr),
        .flash_start(flash_start), .flash_prog(flash_prog), .flash_page(flash_page),
        .flash_ack(flash_ack), .ld_valid(ld_valid), .ld_data(ld_data),
        .halt(halt), .busy(busy)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (6) cyc();
    endtask

    // erase/program run; returns halt length
    task automatic long_op(bit prog, int ack_at, bit disturb, output int n);
        zptr = 16'hB7C3;
        wr(prog ? 8'h05 : 8'h03);
        store_strobe = 1'b1;
        cyc();
        store_strobe = 1'b0;
        check("R5 start", int'(flash_start), 1);
        check("R5 page", int'(flash_page), int'(16'hB7C3 >> 6));
        check("R5 kind", int'(flash_prog), int'(prog));
        check("R6 halt", int'(halt && busy), 1);
        n = 0;
        while (halt && n < 500) begin
            check("R6 image", int'(reg_rdata), prog ? 8'h05 : 8'h03);
            flash_ack = (n == ack_at);
            if (disturb && n == 3) begin
                reg_we = 1'b1;
                reg_wdata = 8'h11;
            end
            if (disturb && (n == 5 || n == 6)) rst_n = 1'b0;
            cyc();
            flash_ack = 1'b0;
            reg_we = 1'b0;
            rst_n = 1'b1;
            n++;
        end
        check("R7 done readback", int'(reg_rdata), 0);
    endtask

    initial begin
        int n;
        repeat (3) cyc();
        check("R1 reset", int'(reg_rdata), 0);
        rst_n = 1'b1;
        cyc();

        // R2/R1: every low pattern with mixed upper bits
        for (int p = 0; p < 32; p++) begin
            logic [7:0] v;
            logic [4:0] pl;
            int exp;
            pl = p[4:0];
            v = {p[2:0] ^ 3'b101, pl};
            exp = (pl == 5'b10001 || pl == 5'b01001 || pl == 5'b00101 ||
                   pl == 5'b00011 || pl == 5'b00001) ? int'(pl) : 0;
            wr(v);
            check("R2 accept", int'(reg_rdata), exp);
            check("R1 upper", int'(reg_rdata[7:5]), 0);
            settle();
            check("R3 expire", int'(reg_rdata), 0);
        end

        // R3/R4: fill strobe at distance d
        for (int d = 1; d <= 5; d++) begin
            zptr = 16'h0040 + 16'(d * 6 + 1);
            r_data = 16'hC000 + 16'(d);
            wr(8'h01);
            repeat (d - 1) cyc();
            store_strobe = 1'b1;
            cyc();
            store_strobe = 1'b0;
            check("R3 window fill", int'(buf_we), int'(d <= 4));
            if (d <= 4) begin
                check("R4 addr", int'(buf_addr), int'(zptr[5:1]));
                check("R4 data", int'(buf_wdata), int'(r_data));
            end
            cyc();
            check("R4 pulse one cycle", int'(buf_we), 0);
            check("R3 cleared", int'(reg_rdata), 0);
            settle();
        end

        // R9: fuse/lock read window and select
        for (int d = 1; d <= 4; d++) begin
            for (int z0 = 0; z0 < 2; z0++) begin
                zptr = 16'h0010 | 16'(z0);
                wr(8'h09);
                repeat (d - 1) cyc();
                load_strobe = 1'b1;
                cyc();
                load_strobe = 1'b0;
                check("R9 window", int'(ld_valid), int'(d <= 3));
                if (d <= 3) check("R9 data", int'(ld_data), z0 ? 8'hA5 : 8'h3C);
                settle();
            end
        end

        // R8: clear
        wr(8'h11);
        store_strobe = 1'b1;
        cyc();
        store_strobe = 1'b0;
        check("R8 clear", int'(buf_clr), 1);
        check("R8 no fill", int'(buf_we), 0);
        cyc();
        check("R8 pulse", int'(buf_clr), 0);
        settle();

        // R12: write and strobe in the same armed cycle
        zptr = 16'h0006;
        r_data = 16'h1234;
        wr(8'h01);
        reg_we = 1'b1;
        reg_wdata = 8'h03;
        store_strobe = 1'b1;
        cyc();
        reg_we = 1'b0;
        store_strobe = 1'b0;
        check("R12 old command runs", int'(buf_we), 1);
        check("R12 no start", int'(flash_start), 0);
        check("R12 write dropped", int'(reg_rdata), 0);
        settle();
        check("R12 stays idle", int'(halt), 0);

        // R1: reset clears armed state
        wr(8'h01);
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        check("R1 reset armed", int'(reg_rdata), 0);
        settle();

        // R5/R6/R7: erase and program, prompt ack
        long_op(1'b0, 0, 1'b0, n);
        check("R7 erase length", n, N + 1);
        settle();
        long_op(1'b1, 2, 1'b0, n);
        check("R7 program length", n, N + 1);
        settle();
        // R7: late ack
        long_op(1'b0, N + 6, 1'b0, n);
        check("R7 late ack", n, N + 7);
        settle();
        // R10/R11: write and reset during erase
        long_op(1'b0, 0, 1'b1, n);
        check("R10 R11 disturbed length", n, N + 1);
        settle();
        check("R7 idle after", int'(halt), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule